// File: doc/BRIEF.md
# Bus Address Generator and Transfer Counter

This block takes the two-word addressing specification a processor places on a 16-bit multiplexed bus and turns it into a 20-bit system-bus address. The first word provides the low address byte, a length field and three control flags. The second word provides address bits 11:8 directly. It also provides eight bits that are relocated by adding an 8-bit offset, and the sum becomes address bits 19:12. After both words are loaded, every advance strobe steps the whole 20-bit address by one byte.

Alongside the address, a transfer counter is preloaded with the ones' complement of the encoded length. It counts up on each advance. A transfer sequencer elsewhere watches the last-byte flag to know when the final byte of the transfer is on the bus. A synchronous active-low initialise input returns every register to zero.

Top module: `busaddr_gen`

## Requirements
- R1: While `init_n` is low at a clock edge, the next cycle shows `addr_out` = 0, `last_cnt` = 0 and all three flags at 0. This applies whatever the other inputs are.
- R2: A `load_lo` cycle loads the following: `bus_in[7:0]` into `addr_out[7:0]`, `bus_in[15]` into `acc_type`, `bus_in[14]` into `op_type` and `bus_in[0]` into `odd_flag`.
- R3: A `load_hi` cycle loads `bus_in[3:0]` into `addr_out[11:8]`. It also loads `(bus_in[11:4] + offset_in) mod 256` into `addr_out[19:12]`: the adder's carry is dropped and `bus_in[15:12]` is not used.
- R4: An `adv` cycle with neither load strobe high adds one to the full 20-bit address. Carries pass between all sections, and 0xFFFFF wraps to 0x00000.
- R5: The length field `bus_in[13:8]` of a `load_lo` cycle holds N-1 for an N-byte transfer. `last_cnt` goes high after exactly N-1 advances, so a field of 0 raises it in the cycle right after the load.
- R6: The advance that completes the Nth byte clears `last_cnt`.
- R7: `adv` has no effect in any cycle in which `load_lo` or `load_hi` is high. In a cycle with no strobe at all, every output holds its value.
- R8: `load_lo` leaves `addr_out[19:8]` unchanged. `load_hi` leaves `addr_out[7:0]`, the flags and the transfer count unchanged.
- R9: `offset_in` is only sampled in a `load_hi` cycle. A change at any other time does not move the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on its rising edge |
| init_n | input | 1 | Synchronous active-low initialise |
| bus_in | input | 16 | Multiplexed addressing-specification bus |
| load_lo | input | 1 | Strobe: bus carries the first specification word |
| load_hi | input | 1 | Strobe: bus carries the second specification word |
| offset_in | input | 8 | Relocation offset added to the middle address bits |
| adv | input | 1 | Per-byte advance strobe |
| addr_out | output | 20 | System-bus byte address |
| acc_type | output | 1 | Latched access-type flag |
| op_type | output | 1 | Latched operation-type flag |
| odd_flag | output | 1 | Latched odd/even flag (address bit 0 at load time) |
| last_cnt | output | 1 | High while the final byte of the transfer is in progress |

## Verification
The hardest situations to reach are a carry that passes through every counter section at once and the last-byte flag of the longest transfer. The address case needs 0xFFFFF as the start address, and the length case needs 63 advances before the flag rises. The bench reaches the address case by choosing first and second words that place all-ones in each section, with a zero offset. It reaches the length case with the maximum length field followed by a long run of advances. A separate test uses a length field of zero and asserts `adv` in the same cycle as a load. In that test a counted advance would wrap the counter and clear the flag, so the flag shows directly whether the advance was ignored.

// File: rtl/busaddr_pkg.sv
package busaddr_pkg;

   typedef struct packed {
      logic acc;
      logic op;
      logic odd;
   } busaddr_ctl_t;

endpackage

// File: rtl/busaddr_stage.sv
module busaddr_stage #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         init_n,
   input  logic         ld,
   input  logic         inc,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   always_ff @(posedge clk) begin
      if (!init_n)
         q <= '0;
      else if (ld)
         q <= d;
      else if (inc)
         q <= q + 1'b1;
   end

endmodule

// File: rtl/busaddr_reloc.sv
module busaddr_reloc #(
   parameter int W = 8
) (
   input  logic [W-1:0] base,
   input  logic [W-1:0] ofs,
   output logic [W-1:0] sum
);

   // result is kept to W bits; the carry falls off the top
   always_comb sum = base + ofs;

endmodule

// File: rtl/busaddr_xfer.sv
module busaddr_xfer #(
   parameter int W = 6
) (
   input  logic         clk,
   input  logic         init_n,
   input  logic         ld,
   input  logic         inc,
   input  logic [W-1:0] len,
   output logic         last
);

   logic [W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!init_n)
         cnt <= '0;
      else if (ld)
         cnt <= ~len;
      else if (inc)
         cnt <= cnt + 1'b1;
   end

   always_comb last = &cnt;

endmodule

// File: rtl/busaddr_gen.sv
module busaddr_gen
   import busaddr_pkg::*;
#(
   parameter int BUS_W   = 16,
   parameter int LO_W    = 8,
   parameter int MID_W   = 4,
   parameter int HI_W    = 8,
   parameter int STAGE_W = 4,
   parameter int LEN_W   = 6,
   localparam int ADDR_W = LO_W + MID_W + HI_W
) (
   input  logic              clk,
   input  logic              init_n,
   input  logic [BUS_W-1:0]  bus_in,
   input  logic              load_lo,
   input  logic              load_hi,
   input  logic [HI_W-1:0]   offset_in,
   input  logic              adv,
   output logic [ADDR_W-1:0] addr_out,
   output logic              acc_type,
   output logic              op_type,
   output logic              odd_flag,
   output logic              last_cnt
);

   localparam int NSTG   = ADDR_W / STAGE_W;
   localparam int LO_STG = LO_W / STAGE_W;
   localparam int LEN_LO = LO_W;
   localparam int LEN_HI = LO_W + LEN_W - 1;
   localparam int REL_LO = MID_W;
   localparam int REL_HI = MID_W + HI_W - 1;

   // elaboration checks on the parameter set
   if ((LO_W % STAGE_W) != 0 || (MID_W % STAGE_W) != 0 || (HI_W % STAGE_W) != 0) begin : g_bad_stage
      $error("address sections must be whole multiples of STAGE_W");
   end
   if (LO_W + LEN_W + 2 > BUS_W) begin : g_bad_first
      $error("first word cannot hold address byte, length field and two type flags");
   end
   if (MID_W + HI_W > BUS_W) begin : g_bad_second
      $error("second word too narrow for the upper address fields");
   end

   logic              adv_en;
   logic [HI_W-1:0]   reloc;
   logic [ADDR_W-1:0] ld_data;
   logic [NSTG-1:0]   carry;
   busaddr_ctl_t      ctl_q;

   always_comb adv_en = adv & ~load_lo & ~load_hi;

   busaddr_reloc #(.W(HI_W)) reloc_i (
      .base (bus_in[REL_HI:REL_LO]),
      .ofs  (offset_in),
      .sum  (reloc)
   );

   always_comb ld_data = {reloc, bus_in[MID_W-1:0], bus_in[LO_W-1:0]};
   always_comb carry[0] = adv_en;

   for (genvar g = 0; g < NSTG; g++) begin : g_stage
      logic               ld_s;
      logic [STAGE_W-1:0] q_s;

      if (g < LO_STG) begin : g_lo
         always_comb ld_s = load_lo;
      end else begin : g_up
         always_comb ld_s = load_hi;
      end

      busaddr_stage #(.W(STAGE_W)) stage_i (
         .clk    (clk),
         .init_n (init_n),
         .ld     (ld_s),
         .inc    (carry[g]),
         .d      (ld_data[g*STAGE_W +: STAGE_W]),
         .q      (q_s)
      );

      always_comb addr_out[g*STAGE_W +: STAGE_W] = q_s;

      if (g < NSTG - 1) begin : g_chain
         always_comb carry[g+1] = carry[g] & (&q_s);
      end
   end

   always_ff @(posedge clk) begin
      if (!init_n)
         ctl_q <= '0;
      else if (load_lo)
         ctl_q <= '{acc: bus_in[BUS_W-1], op: bus_in[BUS_W-2], odd: bus_in[0]};
   end

   always_comb begin
      acc_type = ctl_q.acc;
      op_type  = ctl_q.op;
      odd_flag = ctl_q.odd;
   end

   busaddr_xfer #(.W(LEN_W)) xfer_i (
      .clk    (clk),
      .init_n (init_n),
      .ld     (load_lo),
      .inc    (adv_en),
      .len    (bus_in[LEN_HI:LEN_LO]),
      .last   (last_cnt)
   );

endmodule

// File: rtl/busaddr_gen_chk.sv
module busaddr_gen_chk #(
   parameter int BUS_W  = 16,
   parameter int LO_W   = 8,
   parameter int MID_W  = 4,
   parameter int HI_W   = 8,
   parameter int LEN_W  = 6,
   parameter int ADDR_W = 20
) (
   input logic              clk,
   input logic              init_n,
   input logic [BUS_W-1:0]  bus_in,
   input logic              load_lo,
   input logic              load_hi,
   input logic [HI_W-1:0]   offset_in,
   input logic              adv,
   input logic [ADDR_W-1:0] addr_out,
   input logic              acc_type,
   input logic              op_type,
   input logic              odd_flag,
   input logic              last_cnt
);

   logic [HI_W-1:0] want_hi;
   always_comb want_hi = bus_in[MID_W+HI_W-1:MID_W] + offset_in;

   assert_init_clears_R1: assert property (@(posedge clk)
      !init_n |=> (addr_out == '0 && !last_cnt && !acc_type && !op_type && !odd_flag));

   assert_lo_load_R2: assert property (@(posedge clk) disable iff (!init_n)
      load_lo |=> (addr_out[LO_W-1:0] == $past(bus_in[LO_W-1:0]) &&
                   acc_type == $past(bus_in[BUS_W-1]) &&
                   op_type  == $past(bus_in[BUS_W-2]) &&
                   odd_flag == $past(bus_in[0])));

   assert_hi_load_R3: assert property (@(posedge clk) disable iff (!init_n)
      (load_hi && !load_lo) |=> (addr_out[ADDR_W-1:LO_W+MID_W] == $past(want_hi) &&
                                 addr_out[LO_W+MID_W-1:LO_W] == $past(bus_in[MID_W-1:0])));

   assert_advance_R4: assert property (@(posedge clk) disable iff (!init_n)
      (adv && !load_lo && !load_hi) |=> addr_out == $past(addr_out) + 1'b1);

   assert_single_last_R5: assert property (@(posedge clk) disable iff (!init_n)
      (load_lo && bus_in[LO_W+LEN_W-1:LO_W] == '0) |=> last_cnt);

   assert_last_drop_R6: assert property (@(posedge clk) disable iff (!init_n)
      (last_cnt && adv && !load_lo && !load_hi) |=> !last_cnt);

   assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!init_n)
      (!adv && !load_lo && !load_hi) |=> ($stable(addr_out) && $stable(last_cnt) && $stable(odd_flag)));

   assert_hi_keeps_lo_R8: assert property (@(posedge clk) disable iff (!init_n)
      (load_hi && !load_lo) |=> (addr_out[LO_W-1:0] == $past(addr_out[LO_W-1:0]) &&
                                 $stable(odd_flag) && $stable(acc_type) && $stable(last_cnt)));

endmodule

bind busaddr_gen busaddr_gen_chk #(
   .BUS_W  (BUS_W),
   .LO_W   (LO_W),
   .MID_W  (MID_W),
   .HI_W   (HI_W),
   .LEN_W  (LEN_W),
   .ADDR_W (ADDR_W)
) chk_i (
   .clk       (clk),
   .init_n    (init_n),
   .bus_in    (bus_in),
   .load_lo   (load_lo),
   .load_hi   (load_hi),
   .offset_in (offset_in),
   .adv       (adv),
   .addr_out  (addr_out),
   .acc_type  (acc_type),
   .op_type   (op_type),
   .odd_flag  (odd_flag),
   .last_cnt  (last_cnt)
);

// File: tb/busaddr_gen_tb_top.sv
module busaddr_gen_tb_top;

   logic        clk = 1'b0;
   logic        init_n = 1'b0;
   logic [15:0] bus_in = '0;
   logic        load_lo = 1'b0;
   logic        load_hi = 1'b0;
   logic [7:0]  offset_in = '0;
   logic        adv = 1'b0;
   logic [19:0] addr_out;
   logic        acc_type;
   logic        op_type;
   logic        odd_flag;
   logic        last_cnt;

   int total = 0;
   int bad   = 0;

   always #2 clk = ~clk;

   busaddr_gen dut_i (
      .clk       (clk),
      .init_n    (init_n),
      .bus_in    (bus_in),
      .load_lo   (load_lo),
      .load_hi   (load_hi),
      .offset_in (offset_in),
      .adv       (adv),
      .addr_out  (addr_out),
      .acc_type  (acc_type),
      .op_type   (op_type),
      .odd_flag  (odd_flag),
      .last_cnt  (last_cnt)
   );

   task automatic step();
      @(negedge clk);
   endtask

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic do_lo(input logic [15:0] w);
      bus_in = w; load_lo = 1'b1; step(); load_lo = 1'b0;
   endtask

   task automatic do_hi(input logic [15:0] w, input logic [7:0] ofs);
      bus_in = w; offset_in = ofs; load_hi = 1'b1; step(); load_hi = 1'b0;
   endtask

   task automatic t_reset();
      init_n = 1'b0; bus_in = 16'hFFFF; adv = 1'b1; step(); step();
      adv = 1'b0;
      chk("R1", "addr after init", addr_out, 20'h0);
      chk("R1", "flags after init", {acc_type, op_type, odd_flag}, 3'b000);
      chk("R1", "last after init", last_cnt, 1'b0);
      init_n = 1'b1; step();
   endtask

   task automatic t_first();
      do_hi(16'h0123, 8'h00);
      do_lo(16'hC2A5);
      chk("R2", "low byte", addr_out[7:0], 8'hA5);
      chk("R2", "acc/op/odd", {acc_type, op_type, odd_flag}, 3'b111);
      chk("R8", "upper kept over load_lo", addr_out[19:8], 12'h123);
      do_lo(16'h0A54);
      chk("R2", "second first-word", addr_out, 20'h12354);
      chk("R2", "flags cleared", {acc_type, op_type, odd_flag}, 3'b000);
   endtask

   task automatic t_second();
      do_hi(16'hF3C7, 8'h50);
      chk("R3", "relocated address", addr_out, 20'h8C754);
      chk("R8", "flags kept over load_hi", {acc_type, op_type, odd_flag}, 3'b000);
      do_hi(16'h0FF1, 8'h02);
      chk("R3", "offset carry dropped", addr_out, 20'h01154);
      offset_in = 8'hAA; step(); step();
      chk("R9", "offset change ignored", addr_out, 20'h01154);
   endtask

   task automatic t_advance();
      do_hi(16'h00FF, 8'h00);
      do_lo(16'h00FE);
      chk("R4", "start point", addr_out, 20'h0FFFE);
      adv = 1'b1; step();
      chk("R4", "plus one", addr_out, 20'h0FFFF);
      step();
      chk("R4", "carry into top section", addr_out, 20'h10000);
      adv = 1'b0;
      do_hi(16'h0FFF, 8'h00);
      do_lo(16'h00FF);
      chk("R4", "all ones", addr_out, 20'hFFFFF);
      adv = 1'b1; step(); adv = 1'b0;
      chk("R4", "wrap to zero", addr_out, 20'h00000);
      step();
      chk("R7", "idle hold", addr_out, 20'h00000);
   endtask

   task automatic t_last();
      do_lo(16'h0300);
      chk("R5", "N=4 not last at load", last_cnt, 1'b0);
      for (int i = 1; i <= 3; i++) begin
         adv = 1'b1; step(); adv = 1'b0;
         chk("R5", $sformatf("N=4 after %0d advances", i), last_cnt, (i == 3) ? 1'b1 : 1'b0);
      end
      step();
      chk("R5", "last holds while idle", last_cnt, 1'b1);
      adv = 1'b1; step(); adv = 1'b0;
      chk("R6", "last cleared by final advance", last_cnt, 1'b0);
      do_lo(16'h0000);
      chk("R5", "N=1 last at once", last_cnt, 1'b1);
      do_lo(16'h3F00);
      adv = 1'b1;
      for (int i = 0; i < 62; i++) step();
      adv = 1'b0;
      chk("R5", "N=64 after 62 advances", last_cnt, 1'b0);
      adv = 1'b1; step(); adv = 1'b0;
      chk("R5", "N=64 after 63 advances", last_cnt, 1'b1);
   endtask

   task automatic t_ignore();
      adv = 1'b1;
      do_lo(16'h0010);
      adv = 1'b0;
      chk("R7", "adv ignored with load_lo (addr)", addr_out[7:0], 8'h10);
      chk("R7", "adv ignored with load_lo (count)", last_cnt, 1'b1);
      adv = 1'b1;
      do_hi(16'h0123, 8'h00);
      adv = 1'b0;
      chk("R7", "adv ignored with load_hi", addr_out, 20'h12310);
      chk("R8", "count kept over load_hi", last_cnt, 1'b1);
   endtask

   task automatic t_midinit();
      do_lo(16'hC1FF);
      adv = 1'b1; step(); step();
      init_n = 1'b0; step();
      adv = 1'b0; init_n = 1'b1;
      chk("R1", "init mid-transfer addr", addr_out, 20'h0);
      chk("R1", "init mid-transfer flags", {acc_type, op_type, odd_flag, last_cnt}, 4'b0000);
   endtask

   initial begin
      #400000;
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      t_reset();
      t_first();
      t_second();
      t_advance();
      t_last();
      t_ignore();
      t_midinit();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule